// File: doc/BRIEF.md
# SIMT Lane-Mask Divergence Stack

This block tracks which lanes of a 64-lane SIMT wave are active while structured conditional regions run. A sequencer sends one command per clock: load, IF, ELSE or ENDIF. IF and load come with a per-lane condition vector. The block keeps the current lane-enable mask. It also holds a LIFO with one saved word per open region, so regions can nest. For IF, the saved word holds the lanes that were live but failed the condition. ELSE merges that word with the current mask, so the entry then holds the full pre-IF mask, and it turns on only the lanes that failed the condition. ENDIF pops the entry and ORs it back in.

After each update a registered skip flag tells the sequencer that the mask is empty, so the body of the region can be branched over. In pixel mode an outermost ENDIF can leave no lanes alive. When it does, the block pulses a null-export request that carries target code 9, and on the next cycle it pulses a wave-terminate request. A push on a full stack, and an ELSE or ENDIF on an empty stack, each set a sticky error flag. Neither changes the mask.

Top module: `lane_mask_stack`

## Requirements
- R1: After reset the mask is all ones, the stack is empty, and skip, export, terminate and both error flags are 0.
- R2: A load command (op code 0) copies the condition vector into the mask and leaves the stack untouched.
- R3: An IF command (op code 1) sets the mask to the old mask AND the condition, and pushes the old mask with the condition lanes cleared.
- R4: An ELSE command (op code 2) replaces the top entry T with T OR mask, and sets the mask to the lanes of that union that were not active.
- R5: An ENDIF command (op code 3) pops the top entry and ORs it into the mask, so the mask from before the matching IF comes back.
- R6: After every load, IF, ELSE or ENDIF that completes, the skip flag equals 1 exactly when the new mask is all zeros. An erroring command leaves the flag as it was.
- R7: An IF that arrives while the stack holds DEPTH entries sets a sticky overflow flag. The mask and the stack stay unchanged.
- R8: An ELSE or ENDIF on an empty stack sets a sticky underflow flag. The mask and the stack stay unchanged.
- R9: In pixel mode, an ENDIF that empties the stack and leaves an all-zero mask produces a one-cycle export pulse with target code 9 in the following cycle, and then a one-cycle terminate pulse in the cycle after that.
- R10: No export or terminate pulse occurs when pixel mode is off, when the mask after the ENDIF is non-zero, or when entries remain on the stack.
- R11: The mask and all flags are registered. They show the effect of a command one clock after it is accepted.
- R12: While the command valid input is low, the mask, skip flag and stack keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 load, 1 IF, 2 ELSE, 3 ENDIF |
| cmd_cond | input | LANES | Per-lane condition for IF or load |
| pixel_mode | input | 1 | Enables early wave termination |
| exec_mask | output | LANES | Current lane-enable mask |
| skip_region | output | 1 | Mask became empty after the last update |
| export_req | output | 1 | Null-export request pulse |
| export_target | output | 6 | Export target code (9) |
| terminate_req | output | 1 | Wave-terminate request pulse |
| overflow_err | output | 1 | Sticky push-on-full error |
| underflow_err | output | 1 | Sticky ELSE/ENDIF-on-empty error |

## Verification
The assertions assume that `pixel_mode` is stable for as long as a command is valid. They also assume that no command is issued in the cycle a terminate request is outstanding. Because of this, the export-to-terminate spacing only has to be checked against the block's own pulses. The stimulus keeps pixel mode fixed across each region sequence. After an export it inserts an idle cycle before the next command, and it resets the block before reusing it after an error.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_IF    = 2'd1,
    OP_ELSE  = 2'd2,
    OP_ENDIF = 2'd3
  } lms_op_e;

  localparam int unsigned TGT_W = 6;
  localparam logic [TGT_W-1:0] NULL_TARGET = 6'h09;
endpackage

// File: rtl/lms_stack.sv
module lms_stack #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          wr_top,
  input  logic [W-1:0]  push_word,
  input  logic [W-1:0]  top_word_in,
  output logic [W-1:0]  top_word,
  output logic [CW-1:0] depth,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt_q;

  assign depth = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (push && cnt_q == CW'(g)) begin
        mem[g] <= push_word;
      end else if (wr_top && cnt_q == CW'(g + 1)) begin
        mem[g] <= top_word_in;
      end
    end
  end

  always_comb begin
    top_word = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) top_word = mem[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (push) begin
      cnt_q <= cnt_q + CW'(1);
    end else if (pop) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/lms_mask_unit.sv
module lms_mask_unit #(
  parameter int unsigned W = 64
) (
  input  lms_pkg::lms_op_e op,
  input  logic [W-1:0]     cond,
  input  logic [W-1:0]     cur_exec,
  input  logic [W-1:0]     top_word,
  output logic [W-1:0]     nxt_exec,
  output logic [W-1:0]     push_word,
  output logic [W-1:0]     merged_top
);
  import lms_pkg::*;

  function automatic logic [W-1:0] taken_lanes(logic [W-1:0] e, logic [W-1:0] c);
    return e & c;
  endfunction

  function automatic logic [W-1:0] parked_lanes(logic [W-1:0] e_old, logic [W-1:0] e_new);
    return e_old ^ e_new;
  endfunction

  function automatic logic [W-1:0] full_region(logic [W-1:0] e, logic [W-1:0] t);
    return e | t;
  endfunction

  function automatic logic [W-1:0] other_path(logic [W-1:0] e, logic [W-1:0] t);
    return (e | t) ^ e;
  endfunction

  logic [W-1:0] if_exec;

  assign if_exec    = taken_lanes(cur_exec, cond);
  assign push_word  = parked_lanes(cur_exec, if_exec);
  assign merged_top = full_region(cur_exec, top_word);

  always_comb begin
    unique case (op)
      OP_LOAD:  nxt_exec = cond;
      OP_IF:    nxt_exec = if_exec;
      OP_ELSE:  nxt_exec = other_path(cur_exec, top_word);
      OP_ENDIF: nxt_exec = cur_exec | top_word;
      default:  nxt_exec = cur_exec;
    endcase
  end
endmodule

// File: rtl/lms_term_seq.sv
module lms_term_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic export_req,
  output logic terminate_req
);
  logic exp_q, term_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= 1'b0;
      term_q <= 1'b0;
    end else begin
      exp_q  <= fire;
      term_q <= exp_q;
    end
  end

  assign export_req    = exp_q;
  assign terminate_req = term_q;
endmodule

// File: rtl/lane_mask_stack.sv
module lane_mask_stack #(
  parameter int unsigned LANES = 64,
  parameter int unsigned DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [LANES-1:0]          cmd_cond,
  input  logic                      pixel_mode,
  output logic [LANES-1:0]          exec_mask,
  output logic                      skip_region,
  output logic                      export_req,
  output logic [lms_pkg::TGT_W-1:0] export_target,
  output logic                      terminate_req,
  output logic                      overflow_err,
  output logic                      underflow_err
);
  import lms_pkg::*;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  lms_op_e         op;
  logic [LANES-1:0] exec_q, mu_exec, mu_push, mu_merged, top_word;
  logic [CW-1:0]   depth;
  logic            full, empty;
  logic            skip_q, ovf_q, unf_q;

  // named internal events
  logic ev_load, ev_push, ev_else, ev_pop, ev_ovf, ev_unf, ev_upd, ev_fire;

  assign op      = lms_op_e'(cmd_op);
  assign ev_load = cmd_valid && op == OP_LOAD;
  assign ev_push = cmd_valid && op == OP_IF && !full;
  assign ev_ovf  = cmd_valid && op == OP_IF && full;
  assign ev_else = cmd_valid && op == OP_ELSE && !empty;
  assign ev_pop  = cmd_valid && op == OP_ENDIF && !empty;
  assign ev_unf  = cmd_valid && (op == OP_ELSE || op == OP_ENDIF) && empty;
  assign ev_upd  = ev_load || ev_push || ev_else || ev_pop;
  assign ev_fire = ev_pop && pixel_mode && depth == CW'(1) && mu_exec == '0;

  lms_mask_unit #(.W(LANES)) mask_i (
    .op         (op),
    .cond       (cmd_cond),
    .cur_exec   (exec_q),
    .top_word   (top_word),
    .nxt_exec   (mu_exec),
    .push_word  (mu_push),
    .merged_top (mu_merged)
  );

  lms_stack #(.W(LANES), .DEPTH(DEPTH)) stack_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (ev_push),
    .pop         (ev_pop),
    .wr_top      (ev_else),
    .push_word   (mu_push),
    .top_word_in (mu_merged),
    .top_word    (top_word),
    .depth       (depth),
    .full        (full),
    .empty       (empty)
  );

  lms_term_seq term_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (ev_fire),
    .export_req    (export_req),
    .terminate_req (terminate_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_q <= '1;
      skip_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      if (ev_upd) begin
        exec_q <= mu_exec;
        skip_q <= (mu_exec == '0);
      end
      if (ev_ovf) ovf_q <= 1'b1;
      if (ev_unf) unf_q <= 1'b1;
    end
  end

  assign exec_mask     = exec_q;
  assign skip_region   = skip_q;
  assign overflow_err  = ovf_q;
  assign underflow_err = unf_q;
  assign export_target = NULL_TARGET;
endmodule

// File: rtl/lms_chk.sv
module lms_chk #(
  parameter int unsigned LANES = 64,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [LANES-1:0] exec_mask,
  input logic             skip_region,
  input logic             export_req,
  input logic             terminate_req,
  input logic             overflow_err,
  input logic             underflow_err,
  input logic             ev_push,
  input logic             ev_upd,
  input logic             ev_ovf,
  input logic             ev_unf,
  input logic [CW-1:0]    depth
);
  // R3
  if_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> ((exec_mask & ~$past(exec_mask)) == '0));
  // R6
  skip_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upd |=> (skip_region == (exec_mask == '0)));
  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> $stable(exec_mask));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |=> overflow_err);
  // R8
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unf |=> $stable(exec_mask));
  // R8
  unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);
  // R9
  term_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    export_req |=> (terminate_req && !export_req));
  // R9
  term_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    terminate_req |-> $past(export_req));
  // R10
  export_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    export_req |-> (exec_mask == '0 && depth == '0));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(exec_mask) && $stable(depth)));
  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));
endmodule

bind lane_mask_stack lms_chk #(.LANES(LANES), .DEPTH(DEPTH)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .exec_mask     (exec_mask),
  .skip_region   (skip_region),
  .export_req    (export_req),
  .terminate_req (terminate_req),
  .overflow_err  (overflow_err),
  .underflow_err (underflow_err),
  .ev_push       (ev_push),
  .ev_upd        (ev_upd),
  .ev_ovf        (ev_ovf),
  .ev_unf        (ev_unf),
  .depth         (depth)
);

// File: tb/lane_mask_stack_tb_top.sv
module lane_mask_stack_tb_top;
  localparam int unsigned LANES = 64;
  localparam int unsigned DEPTH = 8;

  typedef struct {
    logic [LANES-1:0] exec;
    logic             skip;
    logic             exp;
    logic             term;
    logic             ovf;
    logic             unf;
    string            req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [1:0]       cmd_op = 2'd0;
  logic [LANES-1:0] cmd_cond = '0;
  logic             pixel_mode = 1'b0;
  logic [LANES-1:0] exec_mask;
  logic             skip_region, export_req, terminate_req;
  logic             overflow_err, underflow_err;
  logic [5:0]       export_target;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  exp_t             sb_q[$];
  logic [LANES-1:0] m_stack[$];
  logic [LANES-1:0] m_exec;
  logic             m_skip, m_ovf, m_unf, m_exp_prev;

  always #10 clk = ~clk;  // 50 MHz

  lane_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_cond(cmd_cond), .pixel_mode(pixel_mode), .exec_mask(exec_mask),
    .skip_region(skip_region), .export_req(export_req),
    .export_target(export_target), .terminate_req(terminate_req),
    .overflow_err(overflow_err), .underflow_err(underflow_err)
  );

  task automatic model_reset();
    m_stack.delete();
    m_exec = '1; m_skip = 0; m_ovf = 0; m_unf = 0; m_exp_prev = 0;
  endtask

  task automatic push_item(logic fire, string req);
    exp_t it;
    it.exec = m_exec; it.skip = m_skip; it.exp = fire; it.term = m_exp_prev;
    it.ovf = m_ovf; it.unf = m_unf; it.req = req;
    sb_q.push_back(it);
    m_exp_prev = fire;
  endtask

  // driver: one command per cycle, expected state goes to the scoreboard
  task automatic drive(logic [1:0] op, logic [LANES-1:0] cond, logic pix, string req);
    logic fire = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_cond = cond; pixel_mode = pix;
    case (op)
      2'd0: begin m_exec = cond; m_skip = (m_exec == '0); end
      2'd1: if (m_stack.size() == DEPTH) m_ovf = 1'b1;
            else begin
              m_stack.push_back(m_exec & ~cond);
              m_exec = m_exec & cond; m_skip = (m_exec == '0);
            end
      2'd2: if (m_stack.size() == 0) m_unf = 1'b1;
            else begin
              logic [LANES-1:0] u;
              u = m_stack[m_stack.size()-1] | m_exec;
              m_stack[m_stack.size()-1] = u;
              m_exec = u & ~m_exec; m_skip = (m_exec == '0);
            end
      default: if (m_stack.size() == 0) m_unf = 1'b1;
            else begin
              m_exec = m_exec | m_stack.pop_back(); m_skip = (m_exec == '0);
              fire = pix && m_stack.size() == 0 && m_exec == '0;
            end
    endcase
    push_item(fire, req);
  endtask

  task automatic idle(string req);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_cond = {LANES{1'b1}}; cmd_op = 2'd1;
    push_item(1'b0, req);
  endtask

  task automatic do_reset();
    wait (sb_q.size() == 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    checks++;
    if (exec_mask !== '1 || skip_region || export_req || terminate_req ||
        overflow_err || underflow_err) begin
      errors++;
      $display("FAIL R1 reset: exec=%h flags=%b%b%b%b%b expected exec=all ones flags=00000",
               exec_mask, skip_region, export_req, terminate_req, overflow_err, underflow_err);
    end
    rst_n = 1'b1;
  endtask

  // monitor: samples 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n && sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (exec_mask !== e.exec || skip_region !== e.skip || export_req !== e.exp ||
            terminate_req !== e.term || overflow_err !== e.ovf ||
            underflow_err !== e.unf || export_target !== 6'h09) begin
          errors++;
          $display("FAIL %s: act exec=%h skip=%b exp=%b term=%b ovf=%b unf=%b tgt=%h | exp exec=%h skip=%b exp=%b term=%b ovf=%b unf=%b tgt=09",
                   e.req, exec_mask, skip_region, export_req, terminate_req,
                   overflow_err, underflow_err, export_target,
                   e.exec, e.skip, e.exp, e.term, e.ovf, e.unf);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [LANES-1:0] PAT_A = 64'hF0F0_1234_FFFF_0001;
  localparam logic [LANES-1:0] PAT_B = 64'h00FF_00FF_AAAA_5555;
  localparam logic [LANES-1:0] PAT_C = 64'h8000_0000_0000_00F1;

  initial begin
    model_reset();
    do_reset();
    // R3 R4 R5: single region, then with a load first (R2)
    drive(2'd1, PAT_A, 1'b0, "R3 if");
    drive(2'd2, '0, 1'b0, "R4 else");
    drive(2'd3, '0, 1'b0, "R5 endif");
    idle("R12 idle");
    drive(2'd0, PAT_B, 1'b0, "R2 load");
    drive(2'd1, PAT_A, 1'b0, "R3 if after load");
    // nested regions
    drive(2'd1, PAT_C, 1'b0, "R3 nested if");
    drive(2'd2, '0, 1'b0, "R4 nested else");
    drive(2'd1, '0, 1'b0, "R6 zero cond skip");
    idle("R12 idle hold skip");
    drive(2'd3, '0, 1'b0, "R5 inner endif");
    drive(2'd3, '0, 1'b0, "R5 mid endif");
    drive(2'd2, '0, 1'b0, "R4 outer else");
    drive(2'd3, '0, 1'b0, "R5 outer endif");
    drive(2'd1, '1, 1'b0, "R3 all taken");
    drive(2'd2, '0, 1'b0, "R6 else all zero skip");
    drive(2'd3, '0, 1'b0, "R5 restore");
    // R8 underflow on empty
    drive(2'd2, '0, 1'b0, "R8 else underflow");
    drive(2'd3, '0, 1'b0, "R8 endif underflow");
    drive(2'd0, PAT_C, 1'b0, "R8 sticky after load");
    do_reset();
    // R7 overflow
    for (int i = 0; i < DEPTH; i++) drive(2'd1, ~(64'h1 << i), 1'b0, "R3 fill");
    drive(2'd1, '0, 1'b0, "R7 overflow");
    idle("R7 overflow hold");
    for (int i = 0; i < DEPTH; i++) drive(2'd3, '0, 1'b0, "R5 drain");
    do_reset();
    // R9 pixel termination
    drive(2'd0, '0, 1'b1, "R2 load zero");
    drive(2'd1, PAT_A, 1'b1, "R3 if dead");
    drive(2'd3, '0, 1'b1, "R9 export pulse");
    idle("R9 terminate pulse");
    idle("R9 pulses end");
    // R10 cases
    drive(2'd1, PAT_B, 1'b0, "R3 if dead nopix");
    drive(2'd3, '0, 1'b0, "R10 pixel off");
    drive(2'd1, PAT_B, 1'b1, "R3 if dead a");
    drive(2'd1, PAT_B, 1'b1, "R3 if dead b");
    drive(2'd3, '0, 1'b1, "R10 stack not empty");
    idle("R10 no terminate");
    drive(2'd3, '0, 1'b1, "R9 outer export");
    idle("R9 outer terminate");
    drive(2'd0, PAT_C, 1'b1, "R2 live load");
    drive(2'd1, '0, 1'b1, "R3 if none");
    drive(2'd3, '0, 1'b1, "R10 mask live");
    idle("R10 no export live");
    idle("R11 settle");
    wait (sb_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule